// File: doc/BRIEF.md
# Cell Voltage Rank Sorter

This block orders the DC-link voltages of the series-connected power cells in one phase of a cascaded H-bridge converter. It does not produce a sorted list of values. Each cell receives its own rank, from 0 to k-1, by relative magnitude. The carrier-placement logic downstream can then use a cell's rank to pick that cell's carrier level directly.

A strobe on `sample_valid` captures the k unsigned 12-bit voltage words and starts an evaluation. The block then compares one pair of cells per clock, walking every unordered pair exactly once. The cell that wins a pair has its counter incremented. When the walk is complete, the counts are copied to registered outputs and `done` pulses for one cycle.

The control is a three-state machine:
- **IDLE**: waits for the strobe and keeps the rank counters and pair walker cleared. Transition *accept* goes to COMPARE when `sample_valid` is high.
- **COMPARE**: handles one pair per cycle. Transition *walk_end* goes to PUBLISH after the last pair.
- **PUBLISH**: loads the output register and raises `done`. Transition *retire* always returns to IDLE.

Top module: `cell_rank_sorter`

## Requirements
- R1: While reset is held, and after it is released, every rank output is 0 and `done` is low until the first evaluation ends.
- R2: A cell with a strictly higher voltage gets a strictly larger rank. The lowest voltage gets rank 0 and the highest gets rank NCELLS-1.
- R3: With three cells where cell0 > cell1 > cell2, the ranks of cells 0, 1 and 2 are 2, 1 and 0.
- R4: With three cells where cell0 < cell2 < cell1, the ranks of cells 0, 1 and 2 are 0, 2 and 1.
- R5: When two voltages are equal, the cell with the lower index ranks above the other.
- R6: After every evaluation the published ranks form a permutation of 0..NCELLS-1.
- R7: `done` is a one-cycle pulse. It is high in the cycle that follows the NCELLS*(NCELLS-1)/2+1-th rising edge after the edge that sampled the strobe.
- R8: The rank outputs change only in a cycle in which `done` is high, and they hold their value between pulses.
- R9: A strobe that arrives during an evaluation is ignored. It changes neither that evaluation's result nor its timing.
- R10: Every evaluation starts from cleared counters, so back-to-back evaluations give results that do not depend on the one before.
- R11: Cell c's voltage sits at bits [c*12 +: 12] of `volt_in`, and its rank sits at bits [c*RW +: RW] of `rank_out`, where RW = clog2(NCELLS).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Strobe that captures `volt_in` and starts an evaluation when idle |
| volt_in | input | NCELLS*VW | Packed unsigned cell voltages, cell 0 in the low bits |
| rank_out | output | NCELLS*RW | Packed registered ranks, cell 0 in the low bits |
| done | output | 1 | One-cycle pulse when new ranks are published |

## Verification
A counter that is not cleared, or a pair that is skipped or visited twice, shows up at the ports at the very next `done` pulse. The result is a duplicated rank, a rank out of range, or an ordering that contradicts the voltages. A broken tie rule shows only on inputs with equal voltages, so the sweep over a small value set includes many ties. A wrong state transition moves `done` away from its fixed latency, or lets a strobe that arrives mid-evaluation disturb the result. Either error is visible within one evaluation of NCELLS*(NCELLS-1)/2+1 cycles.

// File: rtl/cell_rank_pkg.sv
package cell_rank_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COMPARE = 2'd1,
        ST_PUBLISH = 2'd2
    } sorter_state_t;

    function automatic int rank_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/crs_pair_walker.sv
module crs_pair_walker #(
    parameter int NCELLS = 3,
    parameter int IW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          step,
    output logic [IW-1:0] idx_a,
    output logic [IW-1:0] idx_b,
    output logic          last
);
    localparam logic [IW-1:0] TOP_IDX  = IW'(NCELLS - 1);
    localparam logic [IW-1:0] LAST_ROW = IW'(NCELLS - 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_a <= '0;
            idx_b <= IW'(1);
        end else if (restart) begin
            idx_a <= '0;
            idx_b <= IW'(1);
        end else if (step && !last) begin
            if (idx_b == TOP_IDX) begin
                idx_a <= idx_a + IW'(1);
                idx_b <= idx_a + IW'(2);
            end else begin
                idx_b <= idx_b + IW'(1);
            end
        end
    end

    assign last = (idx_a == LAST_ROW) && (idx_b == TOP_IDX);
endmodule

// File: rtl/crs_pair_compare.sv
module crs_pair_compare #(
    parameter int VW = 12,
    parameter int IW = 2
) (
    input  logic [VW-1:0] volt_a,
    input  logic [VW-1:0] volt_b,
    input  logic [IW-1:0] idx_a,
    input  logic [IW-1:0] idx_b,
    output logic [IW-1:0] winner
);
    // idx_a is always the lower index, so a tie goes to it
    always_comb begin
        winner = (volt_a >= volt_b) ? idx_a : idx_b;
    end
endmodule

// File: rtl/crs_rank_counters.sv
module crs_rank_counters #(
    parameter int NCELLS = 3,
    parameter int IW     = 2,
    parameter int RW     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 inc_en,
    input  logic [IW-1:0]        win_idx,
    output logic [NCELLS*RW-1:0] counts
);
    for (genvar c = 0; c < NCELLS; c++) begin : g_cell
        logic [RW-1:0] cnt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (clear) begin
                cnt_q <= '0;
            end else if (inc_en && (win_idx == IW'(c))) begin
                cnt_q <= cnt_q + RW'(1);
            end
        end
        assign counts[c*RW +: RW] = cnt_q;
    end
endmodule

// File: rtl/cell_rank_sorter.sv
module cell_rank_sorter
    import cell_rank_pkg::*;
#(
    parameter int NCELLS = 3,
    parameter int VW     = 12,
    localparam int RW    = rank_bits(NCELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_valid,
    input  logic [NCELLS*VW-1:0] volt_in,
    output logic [NCELLS*RW-1:0] rank_out,
    output logic                 done
);
    localparam int IW = rank_bits(NCELLS);

    sorter_state_t        state_q, state_d;
    logic [NCELLS*VW-1:0] volt_q;
    logic [IW-1:0]        idx_a, idx_b, winner;
    logic                 last_pair;
    logic [NCELLS*RW-1:0] counts;
    logic [VW-1:0]        volt_a, volt_b;
    logic                 in_idle, in_compare;

    assign in_idle    = (state_q == ST_IDLE);
    assign in_compare = (state_q == ST_COMPARE);

    // next state: accept, walk_end, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (sample_valid) state_d = ST_COMPARE;
            ST_COMPARE: if (last_pair)    state_d = ST_PUBLISH;
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       volt_q <= '0;
        else if (in_idle && sample_valid) volt_q <= volt_in;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rank_out <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_PUBLISH: begin
                    rank_out <= counts;
                    done     <= 1'b1;
                end
                ST_IDLE, ST_COMPARE: ;
                default: ;
            endcase
        end
    end

    assign volt_a = volt_q[idx_a*VW +: VW];
    assign volt_b = volt_q[idx_b*VW +: VW];

    crs_pair_walker #(.NCELLS(NCELLS), .IW(IW)) u_walker (
        .clk(clk), .rst_n(rst_n), .restart(in_idle), .step(in_compare),
        .idx_a(idx_a), .idx_b(idx_b), .last(last_pair)
    );

    crs_pair_compare #(.VW(VW), .IW(IW)) u_compare (
        .volt_a(volt_a), .volt_b(volt_b), .idx_a(idx_a), .idx_b(idx_b),
        .winner(winner)
    );

    crs_rank_counters #(.NCELLS(NCELLS), .IW(IW), .RW(RW)) u_counters (
        .clk(clk), .rst_n(rst_n), .clear(in_idle), .inc_en(in_compare),
        .win_idx(winner), .counts(counts)
    );
endmodule

// File: rtl/cell_rank_sorter_checker.sv
module cell_rank_sorter_checker #(
    parameter int NCELLS = 3,
    parameter int RW     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sample_valid,
    input logic [NCELLS*RW-1:0] rank_out,
    input logic                 done
);
    localparam int LAT = NCELLS * (NCELLS - 1) / 2 + 1;
    localparam int CW  = $clog2(LAT + 3);
    localparam int MW  = 1 << RW;
    localparam logic [MW-1:0] FULL = MW'((64'd1 << NCELLS) - 64'd1);

    logic [CW-1:0] since_go;
    logic [MW-1:0] seen;

    // independent latency model: cycles since the accepted strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_go <= '0;
        end else if (since_go == '0 || since_go == CW'(LAT + 1)) begin
            since_go <= sample_valid ? CW'(1) : '0;
        end else begin
            since_go <= since_go + CW'(1);
        end
    end

    always_comb begin
        seen = '0;
        for (int c = 0; c < NCELLS; c++) seen[rank_out[c*RW +: RW]] = 1'b1;
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_go == CW'(LAT + 1)));
    assert_rank_permutation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seen == FULL));
    assert_ranks_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rank_out != $past(rank_out)) |-> done);
endmodule

bind cell_rank_sorter cell_rank_sorter_checker #(.NCELLS(NCELLS), .RW(RW)) u_checker (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .rank_out(rank_out), .done(done)
);

// File: tb/cell_rank_sorter_bench.sv
module cell_rank_sorter_bench;
    localparam int  NC      = 3;
    localparam int  VW      = 12;
    localparam int  RW      = 2;
    localparam int  LAT     = NC * (NC - 1) / 2 + 1;
    localparam time CLK_PER = 10ns;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                sample_valid = 1'b0;
    logic [NC*VW-1:0]    volt_in = '0;
    logic [NC*RW-1:0]    rank_out;
    logic                done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_PER / 2) clk = ~clk;

    cell_rank_sorter #(.NCELLS(NC), .VW(VW)) u_cell_rank_sorter (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .volt_in(volt_in), .rank_out(rank_out), .done(done)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_rank(input int v[NC], input int c);
        int r = 0;
        for (int d = 0; d < NC; d++)
            if (d != c && (v[c] > v[d] || (v[c] == v[d] && c < d))) r++;
        return r;
    endfunction

    function automatic int got_rank(input int c);
        return int'(rank_out[c*RW +: RW]);
    endfunction

    // apply one evaluation; poke raises a stray strobe during the evaluation
    task automatic evaluate(input int v[NC], input bit poke, input string req);
        int lat = 0;
        int mask = 0;
        @(negedge clk);
        for (int c = 0; c < NC; c++) volt_in[c*VW +: VW] = VW'(v[c]);
        sample_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
        if (poke) begin
            volt_in = ~volt_in;
            sample_valid = 1'b1;
        end
        while (!done && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            sample_valid = 1'b0;
        end
        check({req, " R7 latency"}, lat, LAT);
        for (int c = 0; c < NC; c++) begin
            check(req, got_rank(c), exp_rank(v, c));
            mask |= 1 << got_rank(c);
        end
        check("R6 permutation", mask, (1 << NC) - 1);
        @(negedge clk);
        check("R7 one-cycle done", int'(done), 0);
    endtask

    initial begin
        int v[NC];
        int vals[4] = '{0, 2047, 2048, 4095};
        logic [NC*RW-1:0] held;

        // R1: reset state
        #(CLK_PER * 3);
        @(negedge clk);
        check("R1 ranks in reset", int'(rank_out), 0);
        check("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ranks after reset", int'(rank_out), 0);
        check("R1 done after reset", int'(done), 0);

        // R3: cell0 > cell1 > cell2 -> 2,1,0
        v = '{3000, 1500, 200};
        evaluate(v, 1'b0, "R3");
        check("R3 cell0", got_rank(0), 2);
        check("R3 cell1", got_rank(1), 1);
        check("R3 cell2", got_rank(2), 0);

        // R4: cell0 < cell2 < cell1 -> 0,2,1
        v = '{100, 4000, 900};
        evaluate(v, 1'b0, "R4");
        check("R4 cell0", got_rank(0), 0);
        check("R4 cell1", got_rank(1), 2);
        check("R4 cell2", got_rank(2), 1);

        // R8: outputs held while idle
        held = rank_out;
        repeat (5) @(negedge clk);
        check("R8 held", int'(rank_out), int'(held));

        // R5: all equal -> lower index ranks higher
        v = '{1234, 1234, 1234};
        evaluate(v, 1'b0, "R5 ties");
        check("R5 cell0 top", got_rank(0), 2);

        // R9: stray strobe mid-evaluation ignored
        v = '{10, 20, 30};
        evaluate(v, 1'b1, "R9 stray strobe");

        // R2/R5/R10/R11: sweep with boundaries and ties, back to back
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int d = 0; d < 4; d++) begin
                    v = '{vals[a], vals[b], vals[d]};
                    evaluate(v, 1'b0, "R2 R5 R10 R11 sweep");
                end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule